// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit core: two active-low external pins, two timer overflow flags and one combined serial flag. Software writes an 8-bit enable register. That register holds a master enable bit and one bit per source. Each external pin can be set to detect a low level or a falling edge. When an enabled request exists and nothing is in service, the controller picks the highest-priority source. It places that source's fixed vector on `irq_vec` and pulses `irq_ack` for one cycle.

The core jumps to the vector and, at the end of the handler, pulses `reti`. That pulse ends the in-service state, and the next pending request can then be taken. The timer and serial flags belong to their peripherals and are only read here. A falling-edge event on an external pin is held in an internal flag until that source is vectored.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq_ack` is 0, `in_service` is 0 and `irq_vec` is 0x0000.
- R2: A write with `en_wr` loads the enable register on the next clock edge. Bit 7 is the master enable, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0 and bit 0 external 0. Bits 6 and 5 always read 0.
- R3: A source is accepted only when both its own enable bit and bit 7 are 1. Either bit alone leaves all outputs idle.
- R4: When several enabled requests are present at once, the winner follows this order from highest to lowest: external 0, timer 0, external 1, timer 1, serial.
- R5: The vectors are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial. `irq_vec` keeps the last vector until the next acceptance.
- R6: A level request present before a clock edge is accepted at that edge. `irq_ack` is high for exactly that one cycle, and `in_service` rises at the same edge.
- R7: While `in_service` is 1, no request is accepted. Requests that arrive during service stay pending. A `reti` pulse clears `in_service` at the next edge, and a pending request is accepted at the edge after that.
- R8: In level mode (`ext_mode` bit = 0), an external pin that is still low after `reti` raises a new acceptance.
- R9: In edge mode (`ext_mode` bit = 1), a high-to-low change of the pin between two clock edges sets a pending flag, and that source is accepted one edge later. The flag is cleared when the source is vectored, so a pin that stays low does not request again. In level mode the flag is held clear.
- R10: An edge-mode pending flag survives while the source is masked. It is accepted once the source and the master bit are enabled, even though the pin has already returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read value |
| ext_mode | input | 2 | Per-pin detect mode, 1 = falling edge, 0 = low level |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow flags |
| ser_flag | input | 1 | Combined serial transmit/receive flag |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| irq_ack | output | 1 | One-cycle acceptance strobe |
| irq_vec | output | 16 | Vector address of the accepted source |
| in_service | output | 1 | High from acceptance until `reti` is taken |

## Verification
The hardest situation to reach from the ports is an edge event captured while its source is masked, and then released later, long after the pin has gone high again. The hidden pending flag is the only record of that event. The bench produces it by pulsing a pin low with the master bit off and restoring the pin. It then writes the enable register and expects the external 1 vector.

Service blocking is reached in a similar way. The bench raises a second request inside an open service window and checks that acceptance waits for the edge after `reti`. Randomised enable values and request patterns, all in level mode, cover the priority order against a bench model.

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
  parameter int NSRC = 5,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  output logic [7:0]       en_rdata,
  input  logic [1:0]       ext_mode,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_flag,
  input  logic             reti,
  output logic             irq_ack,
  output logic [VEC_W-1:0] irq_vec,
  output logic             in_service
);
  localparam int IW = $clog2(NSRC);

  logic [7:0]      en_q;
  logic [1:0]      ext_prev, edge_pend;
  logic [1:0]      ext_req;
  logic [NSRC-1:0] req, masked;
  logic [IW-1:0]   win;
  logic            take;

  assign en_rdata = en_q;

  // per-source request; bit index equals priority rank (0 = highest)
  assign ext_req = (ext_mode & edge_pend) | (~ext_mode & ~ext_n);
  assign req     = {ser_flag, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
  assign masked  = req & en_q[NSRC-1:0] & {NSRC{en_q[7]}};
  assign take    = !in_service && (|masked);

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (masked[i]) win = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 8'h00;
    else if (en_wr) en_q <= en_wdata & 8'h9F;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev  <= 2'b11;
      edge_pend <= 2'b00;
    end else begin
      ext_prev <= ext_n;
      for (int p = 0; p < 2; p++) begin
        if (!ext_mode[p])
          edge_pend[p] <= 1'b0;
        else if (ext_prev[p] && !ext_n[p])
          edge_pend[p] <= 1'b1;
        else if (take && win == IW'(2 * p))
          edge_pend[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack    <= 1'b0;
      irq_vec    <= '0;
      in_service <= 1'b0;
    end else begin
      irq_ack <= take;
      if (take) begin
        irq_vec    <= VEC_W'(3 + 8 * win);
        in_service <= 1'b1;
      end else if (reti) begin
        in_service <= 1'b0;
      end
    end
  end

  assert_ack_marks_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> in_service);

  assert_no_accept_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !reti) |=> !irq_ack);

  assert_ack_needs_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(en_rdata[7]));

  assert_ack_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B || irq_vec == 16'h0013 ||
                 irq_vec == 16'h001B || irq_vec == 16'h0023));

  assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[6:5] == 2'b00);
endmodule

// File: tb/irq_prio_ctl_bench.sv
module irq_prio_ctl_bench;
  logic        clk = 0, rst_n = 0;
  logic        en_wr = 0;
  logic [7:0]  en_wdata = 0;
  logic [7:0]  en_rdata;
  logic [1:0]  ext_mode = 0, ext_n = 2'b11, tmr_ovf = 0;
  logic        ser_flag = 0, reti = 0;
  logic        irq_ack, in_service;
  logic [15:0] irq_vec;
  int          errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  irq_prio_ctl u_irq_prio_ctl (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [7:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0;
  endtask

  // priority model: lowest set bit of the masked request wins
  function automatic logic [15:0] exp_vec(logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return 16'(3 + 8 * i);
    return 16'h0;
  endfunction

  initial begin
    void'($urandom(1234));
    tick(2);
    chk("R1 en", 16'(en_rdata), 0); chk("R1 ack", 16'(irq_ack), 0);
    chk("R1 insvc", 16'(in_service), 0); chk("R1 vec", irq_vec, 0);
    rst_n = 1; tick();

    wr_en(8'hFF); chk("R2 readback", 16'(en_rdata), 16'h9F);
    wr_en(8'h00);

    // R3: either enable alone is not enough
    ser_flag = 1; wr_en(8'h10); tick(2);
    chk("R3 source-only ack", 16'(irq_ack), 0); chk("R3 source-only svc", 16'(in_service), 0);
    wr_en(8'h80); tick(2);
    chk("R3 master-only svc", 16'(in_service), 0);
    ser_flag = 0; wr_en(8'h90); ser_flag = 1; tick();
    chk("R3/R6 both ack", 16'(irq_ack), 1); chk("R5 serial vec", irq_vec, 16'h0023);
    ser_flag = 0; tick();
    chk("R6 ack single", 16'(irq_ack), 0); chk("R5 vec held", irq_vec, 16'h0023);
    do_reti(); chk("R7 reti clears", 16'(in_service), 0);

    // R4: everything at once
    wr_en(8'h9F);
    ext_n = 2'b00; tmr_ovf = 2'b11; ser_flag = 1; tick();
    chk("R4 all pending", irq_vec, 16'h0003);
    ext_n = 2'b11; tmr_ovf = 0; ser_flag = 0; do_reti();

    // R7: request arriving during service waits
    tmr_ovf = 2'b10; tick();
    chk("R7 first ack", irq_vec, 16'h001B);
    tmr_ovf = 2'b01; tick(3);
    chk("R7 blocked", 16'(in_service), 1); chk("R7 vec unchanged", irq_vec, 16'h001B);
    reti = 1; tick(); reti = 0;
    chk("R7 not same edge", 16'(irq_ack), 0);
    tick();
    chk("R7 ack after reti", 16'(irq_ack), 1); chk("R7 pending vec", irq_vec, 16'h000B);
    tmr_ovf = 0; do_reti(); tick();

    // R8: level re-request
    ext_mode = 2'b00; ext_n = 2'b01; tick();
    chk("R8 first", irq_vec, 16'h0013);
    do_reti(); tick();
    chk("R8 re-raised", 16'(irq_ack), 1); chk("R8 vec", irq_vec, 16'h0013);
    ext_n = 2'b11; do_reti(); tick();

    // R9: edge mode
    ext_mode = 2'b01; tick(); ext_n = 2'b10; tick();
    chk("R9 latch cycle", 16'(irq_ack), 0);
    tick();
    chk("R9 edge ack", 16'(irq_ack), 1); chk("R9 edge vec", irq_vec, 16'h0003);
    do_reti(); tick(3);
    chk("R9 no re-request", 16'(in_service), 0);
    ext_n = 2'b11; ext_mode = 0; tick();

    // R10: edge captured while masked, released later
    wr_en(8'h00); ext_mode = 2'b10; tick();
    ext_n = 2'b01; tick(); ext_n = 2'b11; tick(3);
    chk("R10 masked idle", 16'(in_service), 0);
    wr_en(8'h84);
    chk("R10 same edge as write", 16'(irq_ack), 0);
    tick();
    chk("R10 released", 16'(irq_ack), 1); chk("R10 vec", irq_vec, 16'h0013);
    do_reti(); ext_mode = 0; tick();

    // random, level mode
    for (int t = 0; t < 60; t++) begin
      logic [7:0] e; logic [4:0] r, m;
      e = 8'($urandom); r = 5'($urandom);
      wr_en(e);
      ext_n = ~{r[2], r[0]}; tmr_ovf = {r[3], r[1]}; ser_flag = r[4];
      m = r & e[4:0] & {5{e[7]}};
      tick();
      chk("R3/R4 rand ack", 16'(irq_ack), 16'(|m));
      if (|m) chk("R4/R5 rand vec", irq_vec, exp_vec(m));
      ext_n = 2'b11; tmr_ovf = 0; ser_flag = 0;
      if (|m) do_reti();
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule